// File: doc/BRIEF.md
# Flash Program/Erase Control Register

This block holds the byte-wide control and status register that steers programming and erasure of an on-chip flash array, plus a small test register next to it. A processor reads and writes both registers over a simple byte bus. The control register sets erase or program mode, opens the programming latches, starts the high-voltage operation and can stop the flash clock during CPU wait. It also shows one read-only status bit that follows a digital supply-sense input.

The block also steers how the array is addressed and read. In special mode a test bit forces row decoding onto the spare test row. A second test bit lets one programming step write two words: the two lowest address bits are dropped, so the words at offsets 00 and 10 get the same latched data. During an active erase, reads of the array return all ones. A bulk erase reaches the boot block only when the boot-protect input is low.

Some control bits are locked while an operation is running, so that a programming or erase step cannot change mode part way through.

Top module: `flash_ctl_reg`

## Requirements
- R1: After reset, every stored bit of both registers is 0. The control register then reads as the status bit alone, and the test register reads 0x00.
- R2: The control register sits at byte address 0xF7 (CTL_ADDR). Bit 4 is the wait-halt bit, bit 3 is supply status, bit 2 is erase mode, bit 1 is latch enable and bit 0 is the operation enable. Bits 7 to 5 always read 0.
- R3: Bit 3 of the control register always reads the current value of `supply_ok`. Writes to bit 3 are ignored.
- R4: A write to the control register changes the erase-mode bit only if the enable bit is 0 before that write. While the enable bit is 1, erase mode holds its value.
- R5: `erase_main` is 1 exactly when erase mode and enable are both 1. `erase_boot` is 1 only when, in addition, `boot_protect` is 0.
- R6: A write of 1 to the wait-halt bit is ignored while `vec_in_flash` is 1; the bit keeps its previous value. `clk_halt` is the wait-halt bit ANDed with `cpu_wait`.
- R7: The test register sits at byte address 0xF6 (TST_ADDR). Bit 1 is the spare-row enable and bit 0 is the multi-word bit. Bits 7 to 2 read 0. Writes to it take effect only while `special_mode` is 1.
- R8: A write to the multi-word bit is ignored while the enable bit is 1.
- R9: When spare-row enable and `special_mode` are both 1, `spare_sel` is 1 and `row_idx` is all ones. Otherwise `spare_sel` is 0 and `row_idx` is `arr_addr[FA_W-1:ROW_LSB]`.
- R10: `pair_prog` is 1 when the multi-word bit and the latch bit are 1 and erase mode is 0. In that case `col_idx` is `arr_addr[ROW_LSB-1:0]` with its two low bits forced to 0. Otherwise `col_idx` passes those address bits through unchanged.
- R11: `cpu_rdata` is all ones while erase mode and enable are both 1. Otherwise it equals `arr_rdata`.
- R12: Writes to any other address change neither register, and reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when no read is selected |
| supply_ok | input | 1 | Digital supply-sense level |
| vec_in_flash | input | 1 | Interrupt vectors live in the flash array |
| special_mode | input | 1 | Special (test) operating mode |
| boot_protect | input | 1 | Protects the boot block from bulk erase |
| cpu_wait | input | 1 | CPU is in wait mode |
| arr_addr | input | FA_W | Array access byte address |
| arr_rdata | input | DATA_W | Raw array read data |
| cpu_rdata | output | DATA_W | Array read data seen by the CPU |
| ctl_erase | output | 1 | Erase mode (0 = program) |
| ctl_latch | output | 1 | Programming latch enable |
| ctl_enable | output | 1 | Program/erase operation enable |
| clk_halt | output | 1 | Stop the flash clock |
| erase_main | output | 1 | Bulk erase of the main array |
| erase_boot | output | 1 | Bulk erase also reaches the boot block |
| spare_sel | output | 1 | Spare test row selected |
| pair_prog | output | 1 | Program two words in one step |
| row_idx | output | FA_W-ROW_LSB | Row index after override |
| col_idx | output | ROW_LSB | In-row byte offset after override |

## Verification
The bench uses the default parameters: a 15-bit array address, 32-byte rows (ROW_LSB = 5), 16-bit array data, and registers at 0xF7 and 0xF6. With these values `row_idx` is 10 bits wide, so the spare-row override produces 0x3FF, which is easy to tell apart from a normal row such as 0x091. `col_idx` is 5 bits wide, so clearing its low two bits (0x17 becomes 0x14) stays visible next to the untouched upper bits. The 16-bit data path makes the forced all-ones read (0xFFFF) distinct from an array pattern such as 0x1234.

// File: rtl/fctl_pkg.sv
// Package: shared register layouts and field positions for the flash
// control block. Assumes byte-wide registers.
package fctl_pkg;

    // Control register field positions (decoded by software, so they are fixed)
    localparam int CTL_ENABLE_BIT = 0;
    localparam int CTL_LATCH_BIT  = 1;
    localparam int CTL_ERASE_BIT  = 2;
    localparam int CTL_STAT_BIT   = 3;
    localparam int CTL_HALT_BIT   = 4;

    // Test register field positions
    localparam int TST_MULTI_BIT  = 0;
    localparam int TST_SPARE_BIT  = 1;

    localparam int REG_W = 8;

    typedef struct packed {
        logic halt;
        logic erase;
        logic latch;
        logic enable;
    } ctl_t;

    typedef struct packed {
        logic spare_en;
        logic multi;
    } tst_t;

endpackage

// File: rtl/fctl_regs.sv
// Module: fctl_regs
// Holds the control and test registers, applies the write interlocks and
// drives the byte read-back. Assumes that a write lands at the clock edge
// where bus_sel and bus_wr are high, and that reads are combinational.
module fctl_regs
    import fctl_pkg::*;
#(
    parameter logic [7:0] CTL_ADDR = 8'hF7,
    parameter logic [7:0] TST_ADDR = 8'hF6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       supply_ok,
    input  logic       vec_in_flash,
    input  logic       special_mode,
    output ctl_t       ctl,
    output tst_t       tst,
    output logic [7:0] bus_rdata
);

    ctl_t ctl_q;
    tst_t tst_q;
    logic hit_ctl;
    logic hit_tst;
    logic wr_ctl;
    logic wr_tst;
    logic rd_en;

    // Address decode and access qualification
    always_comb begin
        hit_ctl = (bus_addr == CTL_ADDR);
        hit_tst = (bus_addr == TST_ADDR);
        wr_ctl  = bus_sel && bus_wr && hit_ctl;
        wr_tst  = bus_sel && bus_wr && hit_tst && special_mode;
        rd_en   = bus_sel && !bus_wr;
    end

    // Control register update with erase lock and halt guard
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q.enable <= bus_wdata[CTL_ENABLE_BIT];
            ctl_q.latch  <= bus_wdata[CTL_LATCH_BIT];
            if (!ctl_q.enable) begin
                ctl_q.erase <= bus_wdata[CTL_ERASE_BIT];
            end
            if (!(vec_in_flash && bus_wdata[CTL_HALT_BIT])) begin
                ctl_q.halt <= bus_wdata[CTL_HALT_BIT];
            end
        end
    end

    // Test register update, special mode only, multi-word locked during enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tst_q <= '0;
        end else if (wr_tst) begin
            tst_q.spare_en <= bus_wdata[TST_SPARE_BIT];
            if (!ctl_q.enable) begin
                tst_q.multi <= bus_wdata[TST_MULTI_BIT];
            end
        end
    end

    // Read-back mux with status mirror and zero-filled unused bits
    always_comb begin
        bus_rdata = '0;
        if (rd_en && hit_ctl) begin
            bus_rdata[CTL_ENABLE_BIT] = ctl_q.enable;
            bus_rdata[CTL_LATCH_BIT]  = ctl_q.latch;
            bus_rdata[CTL_ERASE_BIT]  = ctl_q.erase;
            bus_rdata[CTL_STAT_BIT]   = supply_ok;
            bus_rdata[CTL_HALT_BIT]   = ctl_q.halt;
        end else if (rd_en && hit_tst) begin
            bus_rdata[TST_MULTI_BIT]  = tst_q.multi;
            bus_rdata[TST_SPARE_BIT]  = tst_q.spare_en;
        end
    end

    // Register outputs to the rest of the block
    always_comb begin
        ctl = ctl_q;
        tst = tst_q;
    end

endmodule

// File: rtl/fctl_addr_map.sv
// Module: fctl_addr_map
// Rewrites the array row and column address for spare-row access and
// two-word programming. Assumes ROW_LSB >= 2, so the two dropped address
// bits lie inside the column field.
module fctl_addr_map
    import fctl_pkg::*;
#(
    parameter int FA_W    = 15,
    parameter int ROW_LSB = 5,
    localparam int ROW_W  = FA_W - ROW_LSB
) (
    input  logic [FA_W-1:0]    arr_addr,
    input  ctl_t               ctl,
    input  tst_t               tst,
    input  logic               special_mode,
    output logic [ROW_W-1:0]   row_idx,
    output logic [ROW_LSB-1:0] col_idx,
    output logic               spare_sel,
    output logic               pair_prog
);

    localparam logic [ROW_W-1:0] SPARE_ROW = '1;

    // Spare-row override of the row decode
    always_comb begin
        spare_sel = tst.spare_en && special_mode;
        row_idx   = spare_sel ? SPARE_ROW : arr_addr[FA_W-1:ROW_LSB];
    end

    // Two-word programming drops the low two address bits
    always_comb begin
        pair_prog = tst.multi && ctl.latch && !ctl.erase;
        col_idx   = arr_addr[ROW_LSB-1:0];
        if (pair_prog) begin
            col_idx[1:0] = 2'b00;
        end
    end

endmodule

// File: rtl/fctl_erase_read.sv
// Module: fctl_erase_read
// Derives bulk-erase strobes with the boot-block mask, the wait-mode clock
// halt, and the forced all-ones read during erase. Purely combinational.
module fctl_erase_read
    import fctl_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  ctl_t              ctl,
    input  logic              boot_protect,
    input  logic              cpu_wait,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              erase_main,
    output logic              erase_boot,
    output logic              clk_halt,
    output logic [DATA_W-1:0] cpu_rdata
);

    logic erasing;

    // Bulk-erase strobes and boot-block mask
    always_comb begin
        erasing    = ctl.erase && ctl.enable;
        erase_main = erasing;
        erase_boot = erasing && !boot_protect;
    end

    // Wait-mode clock halt request
    always_comb begin
        clk_halt = ctl.halt && cpu_wait;
    end

    // Array read data, forced high while erasing
    always_comb begin
        cpu_rdata = erasing ? {DATA_W{1'b1}} : arr_rdata;
    end

endmodule

// File: rtl/flash_ctl_reg.sv
// Module: flash_ctl_reg (top)
// Flash program/erase control register with interlocks, address overrides
// and erase-side read forcing. Assumes one clock domain and a synchronous
// active-low reset.
module flash_ctl_reg
    import fctl_pkg::*;
#(
    parameter int          FA_W     = 15,
    parameter int          ROW_LSB  = 5,
    parameter int          DATA_W   = 16,
    parameter logic [7:0]  CTL_ADDR = 8'hF7,
    parameter logic [7:0]  TST_ADDR = 8'hF6,
    localparam int         ROW_W    = FA_W - ROW_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic               supply_ok,
    input  logic               vec_in_flash,
    input  logic               special_mode,
    input  logic               boot_protect,
    input  logic               cpu_wait,
    input  logic [FA_W-1:0]    arr_addr,
    input  logic [DATA_W-1:0]  arr_rdata,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               ctl_erase,
    output logic               ctl_latch,
    output logic               ctl_enable,
    output logic               clk_halt,
    output logic               erase_main,
    output logic               erase_boot,
    output logic               spare_sel,
    output logic               pair_prog,
    output logic [ROW_W-1:0]   row_idx,
    output logic [ROW_LSB-1:0] col_idx
);

    ctl_t ctl;
    tst_t tst;

    fctl_regs #(
        .CTL_ADDR (CTL_ADDR),
        .TST_ADDR (TST_ADDR)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .supply_ok    (supply_ok),
        .vec_in_flash (vec_in_flash),
        .special_mode (special_mode),
        .ctl          (ctl),
        .tst          (tst),
        .bus_rdata    (bus_rdata)
    );

    fctl_addr_map #(
        .FA_W    (FA_W),
        .ROW_LSB (ROW_LSB)
    ) u_map (
        .arr_addr     (arr_addr),
        .ctl          (ctl),
        .tst          (tst),
        .special_mode (special_mode),
        .row_idx      (row_idx),
        .col_idx      (col_idx),
        .spare_sel    (spare_sel),
        .pair_prog    (pair_prog)
    );

    fctl_erase_read #(
        .DATA_W (DATA_W)
    ) u_erd (
        .ctl          (ctl),
        .boot_protect (boot_protect),
        .cpu_wait     (cpu_wait),
        .arr_rdata    (arr_rdata),
        .erase_main   (erase_main),
        .erase_boot   (erase_boot),
        .clk_halt     (clk_halt),
        .cpu_rdata    (cpu_rdata)
    );

    // Control bits brought out to the array model
    always_comb begin
        ctl_erase  = ctl.erase;
        ctl_latch  = ctl.latch;
        ctl_enable = ctl.enable;
    end

endmodule

// File: rtl/fctl_checker.sv
// Module: fctl_checker
// Concurrent assertions on the top-level ports, attached by bind.
module fctl_checker #(
    parameter int         FA_W     = 15,
    parameter int         ROW_LSB  = 5,
    parameter int         DATA_W   = 16,
    parameter logic [7:0] CTL_ADDR = 8'hF7,
    localparam int        ROW_W    = FA_W - ROW_LSB
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [7:0]         bus_addr,
    input logic [7:0]         bus_rdata,
    input logic               supply_ok,
    input logic               special_mode,
    input logic               boot_protect,
    input logic               cpu_wait,
    input logic [DATA_W-1:0]  arr_rdata,
    input logic [DATA_W-1:0]  cpu_rdata,
    input logic               ctl_erase,
    input logic               ctl_latch,
    input logic               ctl_enable,
    input logic               clk_halt,
    input logic               erase_main,
    input logic               erase_boot,
    input logic               spare_sel,
    input logic               pair_prog,
    input logic [ROW_W-1:0]   row_idx,
    input logic [ROW_LSB-1:0] col_idx
);

    logic rd_ctl;
    assign rd_ctl = bus_sel && !bus_wr && (bus_addr == CTL_ADDR);

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |-> (bus_rdata[7:5] == 3'b000));

    assert_status_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |-> (bus_rdata[3] == supply_ok));

    assert_erase_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_enable |=> $stable(ctl_erase));

    assert_boot_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        erase_boot |-> (erase_main && !boot_protect));

    assert_halt_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_halt |-> cpu_wait);

    assert_spare_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
        spare_sel |-> (special_mode && (row_idx == {ROW_W{1'b1}})));

    assert_pair_col_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pair_prog |-> ((col_idx[1:0] == 2'b00) && ctl_latch && !ctl_erase));

    assert_read_force_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_erase && ctl_enable) |-> (cpu_rdata == {DATA_W{1'b1}}));

    assert_read_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_erase && ctl_enable) |-> (cpu_rdata == arr_rdata));

endmodule

bind flash_ctl_reg fctl_checker #(
    .FA_W     (FA_W),
    .ROW_LSB  (ROW_LSB),
    .DATA_W   (DATA_W),
    .CTL_ADDR (CTL_ADDR)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .supply_ok    (supply_ok),
    .special_mode (special_mode),
    .boot_protect (boot_protect),
    .cpu_wait     (cpu_wait),
    .arr_rdata    (arr_rdata),
    .cpu_rdata    (cpu_rdata),
    .ctl_erase    (ctl_erase),
    .ctl_latch    (ctl_latch),
    .ctl_enable   (ctl_enable),
    .clk_halt     (clk_halt),
    .erase_main   (erase_main),
    .erase_boot   (erase_boot),
    .spare_sel    (spare_sel),
    .pair_prog    (pair_prog),
    .row_idx      (row_idx),
    .col_idx      (col_idx)
);

// File: tb/sim_flash_ctl_reg.sv
module sim_flash_ctl_reg;

    localparam int PERIOD  = 10;
    localparam int FA_W    = 15;
    localparam int ROW_LSB = 5;
    localparam int DATA_W  = 16;
    localparam int ROW_W   = FA_W - ROW_LSB;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               bus_sel = 1'b0;
    logic               bus_wr = 1'b0;
    logic [7:0]         bus_addr = 8'h00;
    logic [7:0]         bus_wdata = 8'h00;
    logic [7:0]         bus_rdata;
    logic               supply_ok = 1'b1;
    logic               vec_in_flash = 1'b0;
    logic               special_mode = 1'b0;
    logic               boot_protect = 1'b1;
    logic               cpu_wait = 1'b0;
    logic [FA_W-1:0]    arr_addr = '0;
    logic [DATA_W-1:0]  arr_rdata = 16'h1234;
    logic [DATA_W-1:0]  cpu_rdata;
    logic               ctl_erase, ctl_latch, ctl_enable, clk_halt;
    logic               erase_main, erase_boot, spare_sel, pair_prog;
    logic [ROW_W-1:0]   row_idx;
    logic [ROW_LSB-1:0] col_idx;

    int errors = 0;
    int checks = 0;

    always #(PERIOD/2) clk = ~clk;

    flash_ctl_reg u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .supply_ok(supply_ok), .vec_in_flash(vec_in_flash),
        .special_mode(special_mode), .boot_protect(boot_protect),
        .cpu_wait(cpu_wait), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
        .cpu_rdata(cpu_rdata), .ctl_erase(ctl_erase), .ctl_latch(ctl_latch),
        .ctl_enable(ctl_enable), .clk_halt(clk_halt), .erase_main(erase_main),
        .erase_boot(erase_boot), .spare_sel(spare_sel), .pair_prog(pair_prog),
        .row_idx(row_idx), .col_idx(col_idx)
    );

    // One stimulus step: write, then read both registers back
    typedef struct packed {
        logic [7:0] addr;
        logic [7:0] data;
        logic       spec;
        logic       vif;
        logic [7:0] exp_ctl;
        logic [7:0] exp_tst;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'hF7, 8'hFF, 1'b0, 1'b1, 8'h0F, 8'h00}, // R6 halt blocked, R3 stat ignored
        '{8'hF7, 8'h03, 1'b0, 1'b0, 8'h0F, 8'h00}, // R4 erase locked
        '{8'hF6, 8'h03, 1'b0, 1'b0, 8'h0F, 8'h00}, // R7 not special
        '{8'hF6, 8'h03, 1'b1, 1'b0, 8'h0F, 8'h02}, // R8 multi locked
        '{8'hF7, 8'h00, 1'b0, 1'b0, 8'h0C, 8'h02}, // R4 erase still locked
        '{8'hF7, 8'h10, 1'b0, 1'b0, 8'h18, 8'h02}, // R6 halt set
        '{8'hF6, 8'h01, 1'b1, 1'b0, 8'h18, 8'h01}, // R7 R8 multi set
        '{8'hF5, 8'hFF, 1'b1, 1'b0, 8'h18, 8'h01}, // R12 other address
        '{8'hF7, 8'h16, 1'b0, 1'b1, 8'h1E, 8'h01}, // R6 halt kept
        '{8'hF7, 8'h00, 1'b0, 1'b0, 8'h08, 8'h01}, // R2 clear
        '{8'hF6, 8'h00, 1'b1, 1'b0, 8'h08, 8'h00}  // R7 clear
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(8'hF7, rd); check("R1 ctl after reset", rd, 8'h08);
        bus_read(8'hF6, rd); check("R1 tst after reset", rd, 8'h00);

        // R2 table walk (per-entry requirement in the table comments)
        for (int i = 0; i < NV; i++) begin
            special_mode = VECS[i].spec;
            vec_in_flash = VECS[i].vif;
            bus_write(VECS[i].addr, VECS[i].data);
            bus_read(8'hF7, rd); check($sformatf("R2 table %0d ctl", i), rd, VECS[i].exp_ctl);
            bus_read(8'hF6, rd); check($sformatf("R7 table %0d tst", i), rd, VECS[i].exp_tst);
        end
        special_mode = 1'b0; vec_in_flash = 1'b0;

        // R12 read of other address
        bus_read(8'hF5, rd); check("R12 other read", rd, 8'h00);

        // R3 status mirror
        supply_ok = 1'b0;
        bus_write(8'hF7, 8'h08);
        bus_read(8'hF7, rd); check("R3 stat low", rd, 8'h00);
        supply_ok = 1'b1;
        bus_read(8'hF7, rd); check("R3 stat high", rd, 8'h08);

        // R5 R11 erase strobes and forced read
        bus_write(8'hF7, 8'h07);
        #1;
        check("R5 erase_main", erase_main, 1);
        check("R5 boot kept", erase_boot, 0);
        check("R11 forced ones", cpu_rdata, 16'hFFFF);
        boot_protect = 1'b0; #1;
        check("R5 boot erased", erase_boot, 1);
        boot_protect = 1'b1;
        bus_write(8'hF7, 8'h00);
        #1;
        check("R4 erase held after enable drop", ctl_erase, 1);
        check("R11 pass through", cpu_rdata, 16'h1234);
        check("R5 erase_main off", erase_main, 0);
        bus_write(8'hF7, 8'h00);
        #1; check("R4 erase cleared", ctl_erase, 0);

        // R6 clock halt
        bus_write(8'hF7, 8'h10);
        #1; check("R6 halt no wait", clk_halt, 0);
        cpu_wait = 1'b1; #1;
        check("R6 halt in wait", clk_halt, 1);
        bus_write(8'hF7, 8'h00);
        #1; check("R6 halt cleared", clk_halt, 0);
        cpu_wait = 1'b0;

        // R9 spare row override
        special_mode = 1'b1;
        bus_write(8'hF6, 8'h02);
        arr_addr = 15'h1234; #1;
        check("R9 spare sel", spare_sel, 1);
        check("R9 spare row", row_idx, 10'h3FF);
        special_mode = 1'b0; #1;
        check("R9 normal sel", spare_sel, 0);
        check("R9 normal row", row_idx, 10'h091);

        // R10 two-word programming
        special_mode = 1'b1;
        bus_write(8'hF6, 8'h01);
        special_mode = 1'b0;
        arr_addr = 15'h0017;
        bus_write(8'hF7, 8'h02);
        #1;
        check("R10 pair on", pair_prog, 1);
        check("R10 col cleared", col_idx, 5'h14);
        bus_write(8'hF7, 8'h06);
        #1;
        check("R10 pair off in erase", pair_prog, 0);
        check("R10 col passed", col_idx, 5'h17);
        bus_write(8'hF7, 8'h00);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_read(8'hF7, rd); check("R1 ctl after second reset", rd, 8'h08);
        bus_read(8'hF6, rd); check("R1 tst after second reset", rd, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule